// File: doc/BRIEF.md
# Receive Frame Slot Manager

This block sits behind the bit-level receiver of a two-wire consumer-control bus and keeps complete incoming frames until a host collects them. Bytes arrive on a byte-valid strobe, and a frame ends on an end-of-frame strobe or is thrown away on an abort strobe. Each finished frame of 1 to 16 bytes (one header byte and up to fifteen payload bytes) is written into a storage slot. There are three slots, or only one when the block runs in single-slot mode. Each slot also records the frame's byte count.

Slots are not a queue. Each slot carries a 2-bit arrival rank: 0 means empty, and occupied slots hold 1, 2 and so on, in arrival order. A new frame goes into the lowest-numbered free slot and takes the next rank. When the host clears a slot, every younger slot moves up one rank, so the host can always find the oldest frame by looking for rank 1. A slot with a non-zero rank raises its ready bit, and the ready bits pass through a mask to a single interrupt line. A frame that finds no free slot is lost and sets a sticky overflow flag.

Top module: `rx_slot_mgr`

## Requirements
- R1: A frame of 1 to 16 bytes that ends with `rx_eof` is stored whole in the chosen slot. Index 0 reads the first (header) byte, index k+1 reads payload byte k, and index 16 reads the byte count. A byte presented with `rx_valid` in the same cycle as `rx_eof` is the frame's last byte.
- R2: A frame that ends with 0 bytes or more than 16 bytes, or that sees `rx_abort`, is discarded. It changes no slot, no rank and no flag.
- R3: Rank field encoding: `ages_o[2s+1:2s]` is slot s. 0 means empty. The occupied slots always hold the distinct values 1..n in arrival order, with 1 the oldest.
- R4: When `mode_multi`=0, only slot 0 is used. A frame that ends while slot 0 is occupied is dropped.
- R5: When `mode_multi`=1, a frame goes to the lowest-numbered free slot and receives rank (number of occupied slots)+1.
- R6: `ready[s]` is high exactly when slot s is occupied. `irq` is high exactly when some slot is both ready and has its `irq_mask` bit set.
- R7: A `host_clr` pulse for an occupied slot sets that slot's rank to 0, drops its ready bit, makes its byte count read 0, and lowers by one every rank above the cleared one. A clear of an empty slot or of slot number 3 has no effect.
- R8: A valid frame that finds no usable free slot is dropped and sets `overflow`. `overflow` stays high until reset.
- R9: When a clear and a frame end fall in the same cycle, the clear is applied first, and the frame may take the slot just freed.
- R10: Host reads are combinational and change no state. Indices at or beyond the byte count (below 16) read 0. Index 17 and above, and slot number 3, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi | input | 1 | 1 selects three slots, 0 selects slot 0 only |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | Frame end strobe |
| rx_abort | input | 1 | Frame abort strobe; overrides all other receive strobes |
| host_clr | input | 1 | Clear pulse for the slot in host_clr_slot |
| host_clr_slot | input | 2 | Slot to clear |
| host_slot | input | 2 | Slot to read |
| host_idx | input | 5 | Byte index to read (0 header, 1..15 payload, 16 count) |
| host_rdata | output | 8 | Read data |
| irq_mask | input | 3 | Per-slot interrupt enables |
| ready | output | 3 | Per-slot occupied flags |
| ages_o | output | 6 | Per-slot 2-bit arrival ranks |
| irq | output | 1 | Masked interrupt |
| overflow | output | 1 | Sticky lost-frame flag |

## Verification
On every cycle, the assertions check that the ranks stay dense and distinct, that a store lands in slot 0 in single-slot mode and leaves its slot ready, that a clear leaves its slot empty unless the same cycle refills it, that a drop raises `overflow` and `overflow` never falls, and that a rising `irq` has a cause. Whether the stored bytes and counts are correct, whether the lowest free slot is chosen, which ranks move after a clear, and how bad frames and the same-cycle clear-and-store ordering behave are shown only by the bench's scenarios. The bench compares these against its own model of slots and ranks.

// File: rtl/rx_slot_pkg.sv
package rx_slot_pkg;
  localparam int SLOTS_DEF = 3;
  localparam int MAXB_DEF  = 16;
  localparam int AGEW_DEF  = 2;
  localparam int LENW_DEF  = 5;

  // Rank of a surviving slot after the slot holding rank 'cut' is freed.
  function automatic logic [AGEW_DEF-1:0] age_step(input logic [AGEW_DEF-1:0] age,
                                                   input logic [AGEW_DEF-1:0] cut);
    if (cut != '0 && age > cut) return age - 1'b1;
    return age;
  endfunction
endpackage

// File: rtl/rx_frame_asm.sv
module rx_frame_asm #(
  parameter int MAXB = 16,
  parameter int LENW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  rx_eof,
  input  logic                  rx_abort,
  output logic                  frm_ok,
  output logic [LENW-1:0]       frm_len,
  output logic [MAXB-1:0][7:0]  frm_bytes
);
  localparam int CW = $clog2(MAXB + 2);
  localparam logic [CW-1:0] SAT = CW'(MAXB + 1);

  logic [CW-1:0]          cnt;
  logic [CW-1:0]          tot;
  logic [MAXB-1:0][7:0]   stage;

  always_comb begin
    tot    = (rx_valid && cnt != SAT) ? cnt + 1'b1 : cnt;
    frm_ok = rx_eof && !rx_abort && tot != '0 && tot <= CW'(MAXB);
    frm_len = LENW'(tot);
    for (int i = 0; i < MAXB; i++)
      frm_bytes[i] = (rx_valid && cnt == CW'(i)) ? rx_byte : stage[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      stage <= '0;
    end else if (rx_abort || rx_eof) begin
      cnt <= '0;
    end else if (rx_valid) begin
      for (int i = 0; i < MAXB; i++)
        if (cnt == CW'(i)) stage[i] <= rx_byte;
      cnt <= tot;
    end
  end
endmodule

// File: rtl/rx_slot_rank.sv
module rx_slot_rank
  import rx_slot_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int SW    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_multi,
  input  logic                          clr_en,
  input  logic [SW-1:0]                 clr_slot,
  input  logic                          store_req,
  output logic [NSLOT-1:0][AGEW_DEF-1:0] ages,
  output logic                          wr_ev,
  output logic [SW-1:0]                 wr_slot,
  output logic                          drop_ev,
  output logic                          clr_ev
);
  logic [NSLOT-1:0][AGEW_DEF-1:0] age_c;
  logic [AGEW_DEF-1:0]            cut;
  logic [AGEW_DEF-1:0]            occ;
  logic [NSLOT-1:0]               free;

  always_comb begin
    cut = '0;
    for (int s = 0; s < NSLOT; s++)
      if (clr_en && clr_slot == SW'(s)) cut = ages[s];
    occ = '0;
    for (int s = 0; s < NSLOT; s++) begin
      age_c[s] = (clr_en && clr_slot == SW'(s)) ? '0 : age_step(ages[s], cut);
      free[s]  = (age_c[s] == '0) && (mode_multi || s == 0);
      if (age_c[s] != '0) occ = occ + 1'b1;
    end
    wr_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (free[s]) wr_slot = SW'(s);
    wr_ev   = store_req && (|free);
    drop_ev = store_req && !(|free);
    clr_ev  = clr_en && cut != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ages <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++)
        ages[s] <= (wr_ev && wr_slot == SW'(s)) ? occ + 1'b1 : age_c[s];
    end
  end
endmodule

// File: rtl/rx_slot_store.sv
module rx_slot_store #(
  parameter int NSLOT = 3,
  parameter int MAXB  = 16,
  parameter int LENW  = 5,
  parameter int SW    = 2,
  parameter int IDXW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ev,
  input  logic [SW-1:0]         wr_slot,
  input  logic                  clr_ev,
  input  logic [SW-1:0]         clr_slot,
  input  logic [MAXB-1:0][7:0]  frm_bytes,
  input  logic [LENW-1:0]       frm_len,
  input  logic [SW-1:0]         rd_slot,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [7:0]            rd_data
);
  logic [NSLOT-1:0][MAXB-1:0][7:0] mem;
  logic [NSLOT-1:0][LENW-1:0]      lens;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem  <= '0;
      lens <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (wr_ev && wr_slot == SW'(s)) begin
          mem[s]  <= frm_bytes;
          lens[s] <= frm_len;
        end else if (clr_ev && clr_slot == SW'(s)) begin
          lens[s] <= '0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_slot == SW'(s)) begin
        for (int i = 0; i < MAXB; i++)
          if (rd_idx == IDXW'(i) && i < int'(lens[s])) rd_data = mem[s][i];
        if (rd_idx == IDXW'(MAXB)) rd_data = 8'(lens[s]);
      end
    end
  end
endmodule

// File: rtl/rx_slot_mgr.sv
module rx_slot_mgr
  import rx_slot_pkg::*;
#(
  parameter int NSLOT = SLOTS_DEF,
  parameter int MAXB  = MAXB_DEF,
  parameter int LENW  = LENW_DEF,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT + 1) : 1,
  localparam int IDXW = $clog2(MAXB + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_multi,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_byte,
  input  logic                      rx_eof,
  input  logic                      rx_abort,
  input  logic                      host_clr,
  input  logic [SW-1:0]             host_clr_slot,
  input  logic [SW-1:0]             host_slot,
  input  logic [IDXW-1:0]           host_idx,
  output logic [7:0]                host_rdata,
  input  logic [NSLOT-1:0]          irq_mask,
  output logic [NSLOT-1:0]          ready,
  output logic [NSLOT*AGEW_DEF-1:0] ages_o,
  output logic                      irq,
  output logic                      overflow
);
  logic                            frm_ok;
  logic [LENW-1:0]                 frm_len;
  logic [MAXB-1:0][7:0]            frm_bytes;
  logic [NSLOT-1:0][AGEW_DEF-1:0]  ages;
  logic                            wr_ev;
  logic [SW-1:0]                   wr_slot;
  logic                            drop_ev;
  logic                            clr_ev;

  rx_frame_asm #(.MAXB(MAXB), .LENW(LENW)) u_asm (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eof(rx_eof), .rx_abort(rx_abort),
    .frm_ok(frm_ok), .frm_len(frm_len), .frm_bytes(frm_bytes)
  );

  rx_slot_rank #(.NSLOT(NSLOT), .SW(SW)) u_rank (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi),
    .clr_en(host_clr), .clr_slot(host_clr_slot), .store_req(frm_ok),
    .ages(ages), .wr_ev(wr_ev), .wr_slot(wr_slot),
    .drop_ev(drop_ev), .clr_ev(clr_ev)
  );

  rx_slot_store #(.NSLOT(NSLOT), .MAXB(MAXB), .LENW(LENW), .SW(SW), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_slot(wr_slot),
    .clr_ev(clr_ev), .clr_slot(host_clr_slot),
    .frm_bytes(frm_bytes), .frm_len(frm_len),
    .rd_slot(host_slot), .rd_idx(host_idx), .rd_data(host_rdata)
  );

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      ready[s] = ages[s] != '0;
      ages_o[s*AGEW_DEF +: AGEW_DEF] = ages[s];
    end
    irq = |(ready & irq_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (drop_ev) overflow <= 1'b1;
  end
endmodule

// File: rtl/rx_slot_mgr_chk.sv
module rx_slot_mgr_chk #(
  parameter int NSLOT = 3,
  parameter int AGEW  = 2,
  parameter int SW    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_multi,
  input logic [NSLOT-1:0]      irq_mask,
  input logic [NSLOT-1:0]      ready,
  input logic [NSLOT*AGEW-1:0] ages_o,
  input logic                  irq,
  input logic                  overflow,
  input logic                  wr_ev,
  input logic [SW-1:0]         wr_slot,
  input logic                  drop_ev,
  input logic                  clr_ev,
  input logic [SW-1:0]         clr_slot
);
  logic [AGEW-1:0] top_rank;
  int              n_occ;

  always_comb begin
    top_rank = '0;
    for (int s = 0; s < NSLOT; s++)
      if (ages_o[s*AGEW +: AGEW] > top_rank) top_rank = ages_o[s*AGEW +: AGEW];
    n_occ = $countones(ready);
  end

  // R3: the highest rank equals the number of occupied slots
  p_rank_dense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(top_rank) == n_occ);

  for (genvar v = 1; v <= NSLOT; v++) begin : g_uniq
    logic [NSLOT-1:0] hit;
    always_comb
      for (int s = 0; s < NSLOT; s++) hit[s] = ages_o[s*AGEW +: AGEW] == AGEW'(v);
    // R3: no two slots share a rank
    p_rank_unique_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  end

  p_single_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !mode_multi) |-> wr_slot == '0);

  p_store_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> ready[$past(wr_slot)]);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_ev) || irq_mask != $past(irq_mask)));

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !(wr_ev && wr_slot == clr_slot)) |=> !ready[$past(clr_slot)]);

  p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> overflow);

  p_no_overflow_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));
endmodule

bind rx_slot_mgr rx_slot_mgr_chk #(.NSLOT(NSLOT), .AGEW(2), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .irq_mask(irq_mask),
  .ready(ready), .ages_o(ages_o), .irq(irq), .overflow(overflow),
  .wr_ev(wr_ev), .wr_slot(wr_slot), .drop_ev(drop_ev), .clr_ev(clr_ev),
  .clr_slot(host_clr_slot)
);

// File: tb/tb_rx_slot_mgr.sv
module tb_rx_slot_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int MB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_multi = 1'b0;
  logic rx_valid = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0, host_clr = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [1:0] host_clr_slot = '0, host_slot = '0;
  logic [4:0] host_idx = '0;
  logic [7:0] host_rdata;
  logic [2:0] irq_mask = '0, ready;
  logic [5:0] ages_o;
  logic irq, overflow;

  rx_slot_mgr dut (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_abort(rx_abort),
    .host_clr(host_clr), .host_clr_slot(host_clr_slot),
    .host_slot(host_slot), .host_idx(host_idx), .host_rdata(host_rdata),
    .irq_mask(irq_mask), .ready(ready), .ages_o(ages_o), .irq(irq), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_age[NS];
  int m_len[NS];
  logic [7:0] m_mem[NS][MB];
  bit m_ovf;
  logic [7:0] fr[MB+4];
  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int occupied();
    int c = 0;
    for (int s = 0; s < NS; s++) if (m_age[s] != 0) c++;
    return c;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_age[s] = 0; m_len[s] = 0;
    end
    m_ovf = 0;
  endtask

  task automatic model_clear(int s);
    int a;
    if (s >= NS || m_age[s] == 0) return;
    a = m_age[s];
    m_age[s] = 0; m_len[s] = 0;
    for (int o = 0; o < NS; o++) if (m_age[o] > a) m_age[o]--;
  endtask

  task automatic model_store(int n);
    int tgt = -1;
    if (n < 1 || n > MB) return;
    for (int s = NS - 1; s >= 0; s--)
      if (m_age[s] == 0 && (mode_multi || s == 0)) tgt = s;
    if (tgt < 0) begin m_ovf = 1; return; end
    m_age[tgt] = occupied() + 1;
    m_len[tgt] = n;
    for (int i = 0; i < n; i++) m_mem[tgt][i] = fr[i];
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  // how: 0 eof alone, 1 eof with last byte, 2 abort after the bytes
  task automatic send_frame(int n, int how, int clr_s);
    int nb;
    for (int i = 0; i < n && i < MB + 4; i++) fr[i] = 8'($urandom);
    nb = (how == 1) ? n - 1 : n;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = (i < MB + 4) ? fr[i] : 8'h5A;
    end
    @(negedge clk);
    rx_valid = (how == 1);
    if (how == 1) rx_byte = fr[n-1];
    rx_eof = (how != 2); rx_abort = (how == 2);
    host_clr = (clr_s >= 0); host_clr_slot = 2'(clr_s);
    @(posedge clk);
    if (clr_s >= 0) model_clear(clr_s);
    if (how != 2) model_store(n);
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; rx_abort = 1'b0; host_clr = 1'b0;
  endtask

  task automatic do_clear(int s);
    @(negedge clk); host_clr = 1'b1; host_clr_slot = 2'(s);
    @(posedge clk); model_clear(s);
    @(negedge clk); host_clr = 1'b0;
  endtask

  task automatic check_ports(string tag);
    logic [5:0] ea;
    int er = 0;
    #1;
    ea = '0;
    for (int s = 0; s < NS; s++) begin
      ea[s*2 +: 2] = 2'(m_age[s]);
      if (m_age[s] != 0) er |= (1 << s);
    end
    chk("R3", {tag, " ranks"}, int'(ages_o), int'(ea));
    chk("R6", {tag, " ready"}, int'(ready), er);
    chk("R6", {tag, " irq"}, int'(irq), int'((er & int'(irq_mask)) != 0));
    chk("R8", {tag, " overflow"}, int'(overflow), int'(m_ovf));
  endtask

  task automatic check_reads(string tag);
    int e;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 18; i++) begin
        @(negedge clk); host_slot = 2'(s); host_idx = 5'(i);
        #2;
        if (s >= NS || i > MB) e = 0;
        else if (i == MB) e = m_len[s];
        else e = (i < m_len[s]) ? int'(m_mem[s][i]) : 0;
        chk((i == MB) ? "R1" : "R10", $sformatf("%s slot%0d idx%0d", tag, s, i),
            int'(host_rdata), e);
      end
    check_ports({tag, " after reads R10"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    do_reset();
    @(negedge clk);
    check_ports("reset");
    chk("R1", "reset count slot0", 0, 0);
    host_slot = 2'd0; host_idx = 5'd16; #2;
    chk("R1", "reset count read", int'(host_rdata), 0);

    // R4 single-slot mode
    irq_mask = 3'b001;
    send_frame(3, 0, -1);
    check_ports("R4 first");
    chk("R4", "slot0 rank", int'(ages_o[1:0]), 1);
    send_frame(5, 1, -1);
    check_ports("R4 second dropped");
    chk("R8", "overflow after drop", int'(overflow), 1);
    check_reads("R4");
    do_clear(0);
    check_ports("R7 clear single");

    // R5 three-slot mode
    do_reset();
    mode_multi = 1'b1; irq_mask = 3'b111;
    send_frame(16, 1, -1);
    send_frame(1, 0, -1);
    send_frame(7, 0, -1);
    chk("R5", "three full ranks", int'(ages_o), 6'b11_10_01);
    check_ports("R5 fill");
    do_clear(1);
    chk("R7", "ranks after clear slot1", int'(ages_o), 6'b10_00_01);
    send_frame(4, 1, -1);
    chk("R5", "refill slot1 rank 3", int'(ages_o), 6'b10_11_01);
    do_clear(0);
    chk("R7", "ranks after clear slot0", int'(ages_o), 6'b01_10_00);
    do_clear(0);
    do_clear(3);
    check_ports("R7 empty and out-of-range clear");
    check_reads("R5");

    // R2 bad frames
    send_frame(17, 0, -1);
    send_frame(0, 0, -1);
    send_frame(6, 2, -1);
    send_frame(18, 1, -1);
    check_ports("R2 bad frames");
    chk("R2", "ranks unchanged", int'(ages_o), 6'b01_10_00);

    // R9 clear and store same cycle
    send_frame(2, 0, -1);
    chk("R9", "full before", int'(ages_o), 6'b01_10_11);
    send_frame(9, 1, 2);
    chk("R9", "store into freed slot2", int'(ages_o), 6'b11_01_10);
    chk("R9", "no overflow", int'(overflow), 0);
    check_reads("R9");
    send_frame(3, 0, -1);
    chk("R8", "overflow when full", int'(overflow), 1);

    // constrained random
    do_reset();
    for (int it = 0; it < 400; it++) begin
      if (it % 80 == 0) begin
        do_reset();
        mode_multi = (it % 160 == 0) ? 1'b1 : 1'b0;
      end
      case ($urandom_range(0, 9))
        0, 1, 2, 3, 4, 5: begin
          int n, how, r, cs;
          n = $urandom_range(0, 18);
          r = $urandom_range(0, 9);
          how = (r == 0) ? 2 : (r < 5 ? 0 : 1);
          if (n == 0 && how == 1) how = 0;
          cs = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 3) : -1;
          send_frame(n, how, cs);
        end
        6, 7, 8: do_clear($urandom_range(0, 3));
        default: begin @(negedge clk); irq_mask = 3'($urandom); end
      endcase
      check_ports($sformatf("rand%0d", it));
      if (it % 25 == 0) check_reads($sformatf("rand%0d", it));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule